// File: doc/BRIEF.md
# Latched 64-bit System Timer

This peripheral keeps a free-running 64-bit time base for a processor subsystem and raises timed events against it. The count advances once every `2*(DIV+1)` input clocks, where DIV is a software-programmed divider. Software therefore picks the tick rate as a fraction of the bus clock. Six 32-bit compare channels watch the low word of the count. Each one sets its own status flag when that word becomes equal to its compare value. A single interrupt line is raised while any flagged channel also has its enable bit set.

The whole 64-bit count cannot be read in one 32-bit access, so software first issues a snapshot command and then reads two snapshot words that hold the same instant. Both count words can also be written directly, which lets software restore the time base after a power-down. The highest compare channel can also serve as a watchdog. When watchdog mode is enabled and that channel matches, a reset request is raised and held until the block itself is reset.

Access is through a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational and have no side effects.

Top module: `tick_timer64`

## Requirements
- R1: While reset is held and after it is released, every register reads 0, `irq` and `wdog_rst` are low, and the prescaler restarts from its first phase.
- R2: With divider value D in the register at byte offset 0x2C (bits 15:0), the count increments exactly once every 2*(D+1) clocks. A divider of 0 gives one increment every second clock.
- R3: The count is 64 bits wide. The low word (offset 0x00) carries into the high word (offset 0x04), and the whole count wraps from all ones to zero.
- R4: A write to offset 0x00 or 0x04 replaces that 32-bit half of the count. If the write falls in a tick cycle, the written value wins and the tick is lost. Count writes do not disturb the prescaler phase.
- R5: A write to offset 0x30 with bit 0 set copies the full count of that cycle into the snapshot words at 0x34 (low) and 0x38 (high). A write with bit 0 clear changes nothing, and offset 0x30 reads 0.
- R6: Compare channel n (value at offset 0x08 + 4n, n = 0..5) sets status bit n in the cycle after the low count word becomes equal to that value. The change can come from counting, a count write or a compare write.
- R7: The status register (offset 0x20, bits 5:0) is write-one-to-clear, and bits written as 0 are unaffected. A match set in the same cycle as a clear of the same bit leaves the bit set.
- R8: `irq` is high exactly while some status bit n and enable bit n (offset 0x24, bits 5:0) are both set.
- R9: If watchdog enable (offset 0x28, bit 0) is set when channel 5 matches, `wdog_rst` rises and stays high until reset. Clearing the enable afterwards does not release it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined enabled-match interrupt |
| wdog_rst | output | 1 | Sticky watchdog reset request |

## Verification
The count is driven under divider 0 and under a larger divider. This shows whether the tick period really follows 2*(D+1) rather than D+1 or a fixed rate. A count loaded just below all ones shows whether the carry from the low word reaches the high word and whether the full 64-bit wrap happens. Count writes are repeated over back-to-back cycles so that some land on tick edges and some do not, which shows whether the write beats the tick. A run of continuous status clears while a compare is crossed shows whether a set takes priority over a clear. The watchdog is checked with its enable both set and then cleared after firing, which shows whether the request is sticky.

// File: rtl/tick_timer64_pkg.sv
package tick_timer64_pkg;

    localparam int TT_DATA_W  = 32;
    localparam int TT_ADDR_W  = 6;
    localparam int TT_NUM_CMP = 6;
    localparam int TT_DIV_W   = 16;

    // Byte offsets of the register map.
    typedef enum logic [TT_ADDR_W-1:0] {
        OFF_CNT_LO  = 6'h00,
        OFF_CNT_HI  = 6'h04,
        OFF_CMP0    = 6'h08,
        OFF_FLAGS   = 6'h20,
        OFF_IRQ_EN  = 6'h24,
        OFF_WD_EN   = 6'h28,
        OFF_DIV     = 6'h2C,
        OFF_SNAP    = 6'h30,
        OFF_SNAP_LO = 6'h34,
        OFF_SNAP_HI = 6'h38
    } tt_off_e;

    // Decoded write strobes for one bus cycle.
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic flags;
        logic irq_en;
        logic wd_en;
        logic div;
        logic snap;
    } tt_wr_t;

    function automatic logic [TT_ADDR_W-1:0] cmp_offset(input int n);
        return TT_ADDR_W'(OFF_CMP0) + TT_ADDR_W'(4 * n);
    endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PC_W = DIV_W + 1;

    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] last_phase;

    // The last phase of a period is 2*div+1.
    assign last_phase = {div, 1'b1};
    assign tick       = (phase_q >= last_phase);

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else if (tick) phase_q <= '0;
        else phase_q <= phase_q + 1'b1;
    end

    // R2: a period is never shorter than two clocks.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                snap_req,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] count,
    output logic [2*DATA_W-1:0] snap
);
    localparam int CNT_W = 2 * DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) count[DATA_W-1:0] <= wdata;
            if (wr_hi) count[CNT_W-1:DATA_W] <= wdata;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) snap <= '0;
        else if (snap_req) snap <= count;
    end

    a_r3_full_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_lo && !wr_hi && (&count)) |=> (count == '0));

    a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count[DATA_W-1:0] == $past(wdata)));

    a_r5_snapshot: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> (snap == $past(count)));

endmodule

// File: rtl/tt_match_bank.sv
module tt_match_bank #(
    parameter int NUM_CMP = 6,
    parameter int DATA_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DATA_W-1:0]              cnt_lo,
    input  logic [NUM_CMP-1:0]             cmp_wr,
    input  logic                           flags_wr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_CMP-1:0][DATA_W-1:0] cmp_q,
    output logic [NUM_CMP-1:0]             flags_q,
    output logic [NUM_CMP-1:0]             hit
);
    logic [NUM_CMP-1:0] equal;
    logic [NUM_CMP-1:0] equal_q;
    logic [NUM_CMP-1:0] clr_mask;

    assign clr_mask = flags_wr ? wdata[NUM_CMP-1:0] : '0;

    for (genvar n = 0; n < NUM_CMP; n++) begin : g_ch
        assign equal[n] = (cnt_lo == cmp_q[n]);
        assign hit[n]   = equal[n] && !equal_q[n];

        always_ff @(posedge clk) begin
            if (rst) cmp_q[n] <= '0;
            else if (cmp_wr[n]) cmp_q[n] <= wdata;
        end

        // R7: set has priority over a same-cycle clear.
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            hit[n] |=> flags_q[n]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            equal_q <= '1;
            flags_q <= '0;
        end else begin
            equal_q <= equal;
            flags_q <= (flags_q & ~clr_mask) | hit;
        end
    end

endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
    import tick_timer64_pkg::*;
#(
    parameter int NUM_CMP = TT_NUM_CMP,
    parameter int DIV_W   = TT_DIV_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_en,
    input  logic [TT_ADDR_W-1:0] bus_addr,
    input  logic [TT_DATA_W-1:0] bus_wdata,
    output logic [TT_DATA_W-1:0] bus_rdata,
    output logic                 irq,
    output logic                 wdog_rst
);
    localparam int DW    = TT_DATA_W;
    localparam int WD_CH = NUM_CMP - 1;

    tt_wr_t                     wr;
    logic [NUM_CMP-1:0]         cmp_wr;
    logic [DIV_W-1:0]           div_q;
    logic [NUM_CMP-1:0]         irq_en_q;
    logic                       wd_en_q;
    logic                       tick;
    logic [2*DW-1:0]            count;
    logic [2*DW-1:0]            snap;
    logic [NUM_CMP-1:0][DW-1:0] cmp_q;
    logic [NUM_CMP-1:0]         flags_q;
    logic [NUM_CMP-1:0]         hit;

    always_comb begin
        wr        = '0;
        wr.cnt_lo = bus_wr_en && (bus_addr == OFF_CNT_LO);
        wr.cnt_hi = bus_wr_en && (bus_addr == OFF_CNT_HI);
        wr.flags  = bus_wr_en && (bus_addr == OFF_FLAGS);
        wr.irq_en = bus_wr_en && (bus_addr == OFF_IRQ_EN);
        wr.wd_en  = bus_wr_en && (bus_addr == OFF_WD_EN);
        wr.div    = bus_wr_en && (bus_addr == OFF_DIV);
        wr.snap   = bus_wr_en && (bus_addr == OFF_SNAP) && bus_wdata[0];
        for (int n = 0; n < NUM_CMP; n++)
            cmp_wr[n] = bus_wr_en && (bus_addr == cmp_offset(n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= '0;
            irq_en_q <= '0;
            wd_en_q  <= 1'b0;
            wdog_rst <= 1'b0;
        end else begin
            if (wr.div)    div_q    <= bus_wdata[DIV_W-1:0];
            if (wr.irq_en) irq_en_q <= bus_wdata[NUM_CMP-1:0];
            if (wr.wd_en)  wd_en_q  <= bus_wdata[0];
            if (wd_en_q && hit[WD_CH]) wdog_rst <= 1'b1;
        end
    end

    tt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk (clk),
        .rst (rst),
        .div (div_q),
        .tick(tick)
    );

    tt_counter #(.DATA_W(DW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_lo   (wr.cnt_lo),
        .wr_hi   (wr.cnt_hi),
        .snap_req(wr.snap),
        .wdata   (bus_wdata),
        .count   (count),
        .snap    (snap)
    );

    tt_match_bank #(.NUM_CMP(NUM_CMP), .DATA_W(DW)) u_match (
        .clk     (clk),
        .rst     (rst),
        .cnt_lo  (count[DW-1:0]),
        .cmp_wr  (cmp_wr),
        .flags_wr(wr.flags),
        .wdata   (bus_wdata),
        .cmp_q   (cmp_q),
        .flags_q (flags_q),
        .hit     (hit)
    );

    assign irq = |(flags_q & irq_en_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CNT_LO:  bus_rdata = count[DW-1:0];
            OFF_CNT_HI:  bus_rdata = count[2*DW-1:DW];
            OFF_FLAGS:   bus_rdata = DW'(flags_q);
            OFF_IRQ_EN:  bus_rdata = DW'(irq_en_q);
            OFF_WD_EN:   bus_rdata = DW'(wd_en_q);
            OFF_DIV:     bus_rdata = DW'(div_q);
            OFF_SNAP_LO: bus_rdata = snap[DW-1:0];
            OFF_SNAP_HI: bus_rdata = snap[2*DW-1:DW];
            default: begin
                for (int n = 0; n < NUM_CMP; n++)
                    if (bus_addr == cmp_offset(n)) bus_rdata = cmp_q[n];
            end
        endcase
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !wdog_rst));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags_q != '0));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> wdog_rst);

endmodule

// File: tb/test_tick_timer64.sv
module test_tick_timer64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdog_rst;

    always #10 clk = ~clk;

    tick_timer64 i_tick_timer64 (
        .clk      (clk),
        .rst      (rst),
        .bus_wr_en(bus_wr_en),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .wdog_rst (wdog_rst)
    );

    // Reference model state
    int          m_pc;
    logic [63:0] m_cnt;
    logic [63:0] m_snap;
    logic [31:0] m_cmp [6];
    logic [5:0]  m_flags;
    logic [5:0]  m_ie;
    logic        m_wde;
    logic [15:0] m_div;
    logic [5:0]  m_eqp;
    logic        m_wd;
    bit          m_valid = 0;

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    string phase   = "R1";
    bit    done    = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_cnt = '0; m_snap = '0; m_flags = '0; m_ie = '0;
            m_wde = 0; m_div = '0; m_eqp = '1; m_wd = 0;
            for (int n = 0; n < 6; n++) m_cmp[n] = '0;
            m_valid = 1;
        end else begin
            bit          tk;
            logic [5:0]  hit;
            logic [63:0] old;
            old = m_cnt;
            tk = (m_pc >= 2 * int'(m_div) + 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int n = 0; n < 6; n++) begin
                hit[n] = (old[31:0] == m_cmp[n]) && !m_eqp[n];
                m_eqp[n] = (old[31:0] == m_cmp[n]);
            end
            if (bus_wr_en && bus_addr == 6'h20) m_flags = m_flags & ~bus_wdata[5:0];
            m_flags = m_flags | hit;
            if (m_wde && hit[5]) m_wd = 1;
            if (tk) m_cnt = old + 1;
            if (bus_wr_en) begin
                if (bus_addr == 6'h00) m_cnt = {old[63:32], bus_wdata};
                if (bus_addr == 6'h04) m_cnt = {bus_wdata, old[31:0]};
                for (int n = 0; n < 6; n++)
                    if (bus_addr == 6'(8 + 4 * n)) m_cmp[n] = bus_wdata;
                if (bus_addr == 6'h24) m_ie = bus_wdata[5:0];
                if (bus_addr == 6'h28) m_wde = bus_wdata[0];
                if (bus_addr == 6'h2C) m_div = bus_wdata[15:0];
                if (bus_addr == 6'h30 && bus_wdata[0]) m_snap = old;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a)
            6'h00: return m_cnt[31:0];
            6'h04: return m_cnt[63:32];
            6'h20: return 32'(m_flags);
            6'h24: return 32'(m_ie);
            6'h28: return 32'(m_wde);
            6'h2C: return 32'(m_div);
            6'h34: return m_snap[31:0];
            6'h38: return m_snap[63:32];
            default: begin
                for (int n = 0; n < 6; n++)
                    if (a == 6'(8 + 4 * n)) return m_cmp[n];
                return '0;
            end
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s at t=%0t: actual=%h expected=%h",
                     req, what, $time, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check(phase, $sformatf("rdata@%h", bus_addr), bus_rdata, model_read(bus_addr));
            check("R8", "irq", 32'(irq), 32'(|(m_flags & m_ie)));
            check("R9", "wdog_rst", 32'(wdog_rst), 32'(m_wd));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            vectors++; misses++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic idle(input int n, input logic [5:0] a);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            bus_wr_en = 0; bus_addr = a;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #2;
        bus_wr_en = 0;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3, 6'h00);
        rst = 0;
        for (int a = 0; a <= 'h38; a += 4) idle(1, 6'(a));

        // R2: tick period for divider 0 and 3
        phase = "R2";
        idle(12, 6'h00);
        wr(6'h2C, 32'd3);
        idle(40, 6'h00);
        wr(6'h2C, 32'd0);
        idle(6, 6'h2C);

        // R5: snapshot command
        phase = "R5";
        wr(6'h30, 32'h1);
        idle(3, 6'h34);
        idle(3, 6'h38);
        wr(6'h30, 32'h0);
        idle(3, 6'h34);
        idle(2, 6'h30);

        // R3: carry and full 64-bit wrap
        phase = "R3";
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h00, 32'hFFFF_FFF8);
        idle(10, 6'h04);
        idle(6, 6'h00);
        wr(6'h30, 32'h1);
        idle(2, 6'h38);

        // R4: count writes colliding with ticks, prescaler phase kept
        phase = "R4";
        @(negedge clk); #2;
        bus_wr_en = 1; bus_addr = 6'h00; bus_wdata = 32'h100;
        for (int i = 0; i < 4; i++) idle(0, 6'h00);
        @(negedge clk); #2; bus_wdata = 32'h200;
        @(negedge clk); #2; bus_wdata = 32'h300;
        @(negedge clk); #2; bus_wr_en = 0;
        idle(8, 6'h00);
        wr(6'h2C, 32'd5);
        wr(6'h00, 32'h40);
        idle(3, 6'h00);
        wr(6'h04, 32'h12);
        idle(30, 6'h00);
        idle(2, 6'h04);
        wr(6'h2C, 32'd0);

        // R6 / R8: compare hits and enabled interrupt
        phase = "R6";
        wr(6'h00, 32'h0);
        wr(6'h08, 32'h8);
        wr(6'h10, 32'h6);
        wr(6'h24, 32'h1);
        idle(24, 6'h20);
        wr(6'h0C, 32'h20);
        idle(2, 6'h0C);

        // R7: write-one-to-clear and set priority
        phase = "R7";
        wr(6'h20, 32'h0);
        idle(2, 6'h20);
        wr(6'h20, 32'h1);
        idle(2, 6'h20);
        wr(6'h24, 32'h2);
        @(negedge clk); #2;
        bus_wr_en = 1; bus_addr = 6'h20; bus_wdata = 32'h3F;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #2;
        end
        bus_wr_en = 0;
        idle(4, 6'h20);
        wr(6'h20, 32'h3F);
        idle(2, 6'h20);

        // R8: irq follows flag and enable combinations
        phase = "R8";
        wr(6'h24, 32'h3F);
        idle(3, 6'h24);
        wr(6'h00, 32'h1F);
        idle(6, 6'h20);
        wr(6'h24, 32'h0);
        idle(2, 6'h20);

        // R9: watchdog request, sticky after enable cleared
        phase = "R9";
        wr(6'h28, 32'h1);
        wr(6'h00, 32'h50);
        wr(6'h1C, 32'h54);
        idle(14, 6'h28);
        wr(6'h28, 32'h0);
        idle(10, 6'h28);

        // R1: reset releases everything
        phase = "R1";
        @(negedge clk); #2; rst = 1;
        idle(2, 6'h00);
        rst = 0;
        for (int a = 0; a <= 'h38; a += 4) idle(1, 6'(a));

        finish_run();
    end

endmodule